// File: doc/BRIEF.md
# Display Serializer Transmit Queue

A byte-granular transmit queue that sits between a register write port and a display serializer. Each write pushes one right-aligned word whose footprint in the queue is 1, 2 or 4 bytes, chosen by the currently configured word size. The serializer drains whole words, one per cycle, and receives the bytes reassembled into a right-aligned word.

The queue tracks its fill level in bytes. It raises a transmit-empty flag whenever one more word of the current size would fit. From that flag it derives an interrupt request and a DMA request, each with its own enable. A flush input empties the queue and forces every flag low for as long as it is held. Normal operation resumes on the first cycle after it is released.

Top module: `dsp_tx_queue`

## Requirements
- R1: Capacity is DEPTH bytes (default 16). `level_o` reports the number of stored bytes and is 0 after reset.
- R2: `size_sel_i` holds the word size in bits minus one. Values 0 to 7 occupy 1 byte, 8 to 15 occupy 2 bytes and 16 to 31 occupy 4 bytes. An accepted write raises `level_o` by that many bytes.
- R3: Write data is right-aligned. Bits at positions above `size_sel_i` are discarded and come out as zero when the word is popped.
- R4: A write that arrives when free space is smaller than one word is dropped. Level and contents stay unchanged.
- R5: `pop_valid_o` is high when the level is at least one word and no flush is active. A pop then presents that word on `pop_data_o`, with the first stored byte in bits 7:0, and removes it on the clock edge. A pop while `pop_valid_o` is low has no effect.
- R6: `tx_empty_o` is high exactly when free space is at least one word of the current size and no flush is active.
- R7: `irq_o` is high exactly when `tx_empty_o` and `irq_en_i` are both high.
- R8: `dma_req_o` is high exactly when `tx_empty_o` and `dma_en_i` are both high.
- R9: While `flush_i` is high the queue empties to level 0, all flags are low, and writes and pops are ignored. Operation resumes the cycle after release.
- R10: When a write and a pop fall in the same cycle, room for the write is judged on the level before the pop, and the level changes by the net amount.
- R11: Words leave in the order they were written, including across pointer wrap-around and changes of word size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| size_sel_i | input | 5 | Word size in bits minus one |
| flush_i | input | 1 | Empty queue and hold flags low |
| wr_en_i | input | 1 | Push one word |
| wr_data_i | input | 32 | Right-aligned write word |
| pop_i | input | 1 | Serializer takes one word |
| pop_valid_o | output | 1 | A full word is available |
| pop_data_o | output | 32 | Word at head of queue |
| level_o | output | 5 | Stored bytes |
| tx_empty_o | output | 1 | Room for one more word |
| irq_en_i | input | 1 | Interrupt enable |
| dma_en_i | input | 1 | DMA request enable |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
Two cases are hard to reach from the ports: a word whose bytes straddle the end of storage, and a full queue that sees a write and a pop in the same cycle. Reaching the straddle requires a level that is not a multiple of the word size when the size changes. The bench therefore runs a long random phase that mixes 1-, 2- and 4-byte sizes, writes, pops and occasional flushes. A behavioural byte queue in the bench follows every cycle. The full-queue collision is driven directly after filling the queue with single bytes.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned SIZE_W     = $clog2(WORD_W);
  localparam int unsigned NB_W       = $clog2(WORD_BYTES) + 1;

  function automatic logic [NB_W-1:0] bytes_for_size(input logic [SIZE_W-1:0] sz);
    if (sz < SIZE_W'(8))       return NB_W'(1);
    else if (sz < SIZE_W'(16)) return NB_W'(2);
    else                       return NB_W'(4);
  endfunction
endpackage

// File: rtl/dsq_size_decode.sv
module dsq_size_decode
  import dsq_pkg::*;
(
  input  logic [SIZE_W-1:0] size_sel_i,
  output logic [NB_W-1:0]   nb_o,
  output logic [WORD_W-1:0] mask_o
);
  assign nb_o = bytes_for_size(size_sel_i);

  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    assign mask_o[i] = (SIZE_W'(i) <= size_sel_i);
  end
endmodule

// File: rtl/dsq_byte_ram.sv
module dsq_byte_ram
  import dsq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     wr_ptr_i,
  input  logic [NB_W-1:0]   nb_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_ptr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int k = 0; k < WORD_BYTES; k++) begin
        if (NB_W'(k) < nb_i) mem_q[wr_ptr_i + AW'(k)] <= wr_data_i[8*k +: 8];
      end
    end
  end

  // head word, lanes beyond the word size read as zero
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_rd
    assign rd_data_o[8*k +: 8] = (NB_W'(k) < nb_i) ? mem_q[rd_ptr_i + AW'(k)] : 8'h00;
  end
endmodule

// File: rtl/dsq_ptr_ctrl.sv
module dsq_ptr_ctrl
  import dsq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LVL_W = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_req_i,
  input  logic             pop_req_i,
  input  logic [NB_W-1:0]  nb_i,
  output logic [AW-1:0]    wr_ptr_o,
  output logic [AW-1:0]    rd_ptr_o,
  output logic [LVL_W-1:0] level_o,
  output logic             space_ok_o,
  output logic             data_ok_o,
  output logic             push_ok_o,
  output logic             pop_ok_o
);
  logic [LVL_W-1:0] nb_ext, free_bytes;

  assign nb_ext     = LVL_W'(nb_i);
  assign free_bytes = LVL_W'(DEPTH) - level_o;
  assign space_ok_o = free_bytes >= nb_ext;
  assign data_ok_o  = level_o >= nb_ext;
  // room is judged on the pre-pop level
  assign push_ok_o  = push_req_i && !flush_i && space_ok_o;
  assign pop_ok_o   = pop_req_i  && !flush_i && data_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
      level_o  <= '0;
    end else if (flush_i) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
      level_o  <= '0;
    end else begin
      if (push_ok_o) wr_ptr_o <= wr_ptr_o + AW'(nb_i);
      if (pop_ok_o)  rd_ptr_o <= rd_ptr_o + AW'(nb_i);
      level_o <= level_o + (push_ok_o ? nb_ext : '0) - (pop_ok_o ? nb_ext : '0);
    end
  end

  assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));
  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0) && (wr_ptr_o == rd_ptr_o));
  assert_drop_no_room_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_i && !flush_i && !space_ok_o && !pop_req_i) |=> $stable(level_o) && $stable(wr_ptr_o));
  assert_pop_drains_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && !flush_i && data_ok_o && !push_req_i) |=>
      (level_o == $past(level_o) - LVL_W'($past(nb_i))));
endmodule

// File: rtl/dsp_tx_queue.sv
module dsp_tx_queue
  import dsq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LVL_W = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] size_sel_i,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic              pop_valid_o,
  output logic [WORD_W-1:0] pop_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              tx_empty_o,
  input  logic              irq_en_i,
  input  logic              dma_en_i,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic [NB_W-1:0]   nb;
  logic [WORD_W-1:0] mask;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              space_ok, data_ok, push_ok, pop_ok;

  dsq_size_decode u_dec (
    .size_sel_i (size_sel_i),
    .nb_o       (nb),
    .mask_o     (mask)
  );

  dsq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .push_req_i (wr_en_i),
    .pop_req_i  (pop_i),
    .nb_i       (nb),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .level_o    (level_o),
    .space_ok_o (space_ok),
    .data_ok_o  (data_ok),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok)
  );

  dsq_byte_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i     (clk_i),
    .we_i      (push_ok),
    .wr_ptr_i  (wr_ptr),
    .nb_i      (nb),
    .wr_data_i (wr_data_i & mask),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (pop_data_o)
  );

  assign pop_valid_o = data_ok && !flush_i;
  assign tx_empty_o  = space_ok && !flush_i;
  assign irq_o       = tx_empty_o && irq_en_i;
  assign dma_req_o   = tx_empty_o && dma_en_i;

  assert_flush_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !irq_o && !dma_req_o && !pop_valid_o);
  assert_full_not_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == LVL_W'(DEPTH)) |-> !tx_empty_o);
  assert_pop_needs_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |-> (level_o != '0));
endmodule

// File: tb/dsp_tx_queue_test.sv
module dsp_tx_queue_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  size_sel_i = '0;
  logic        flush_i = 1'b0, wr_en_i = 1'b0, pop_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        irq_en_i = 1'b0, dma_en_i = 1'b0;
  logic        pop_valid_o, tx_empty_o, irq_o, dma_req_o;
  logic [31:0] pop_data_o;
  logic [4:0]  level_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  byte unsigned q[$];

  always #10 clk_i = ~clk_i;

  dsp_tx_queue uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .size_sel_i(size_sel_i), .flush_i(flush_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .pop_i(pop_i),
    .pop_valid_o(pop_valid_o), .pop_data_o(pop_data_o), .level_o(level_o),
    .tx_empty_o(tx_empty_o), .irq_en_i(irq_en_i), .dma_en_i(dma_en_i),
    .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nbytes(input logic [4:0] sz);
    return (sz < 8) ? 1 : (sz < 16) ? 2 : 4;
  endfunction

  // one cycle: drive, compare against model, advance model
  task automatic cyc(input logic [4:0] sz, input bit fl, input bit we, input logic [31:0] wd,
                     input bit pp, input bit ie, input bit de);
    int nb, sz_q;
    bit te, pv, pop_ok, push_ok;
    logic [31:0] m, d;
    @(negedge clk_i);
    size_sel_i = sz; flush_i = fl; wr_en_i = we; wr_data_i = wd; pop_i = pp;
    irq_en_i = ie; dma_en_i = de;
    #2;
    nb = nbytes(sz);
    sz_q = q.size();
    te = !fl && (16 - sz_q >= nb);
    pv = !fl && (sz_q >= nb);
    chk(level_o == 5'(sz_q), "R1 level", level_o, sz_q);
    chk(tx_empty_o == te, "R6 tx_empty", tx_empty_o, te);
    chk(irq_o == (te && ie), "R7 irq", irq_o, te && ie);
    chk(dma_req_o == (te && de), "R8 dma", dma_req_o, te && de);
    chk(pop_valid_o == pv, "R5 pop_valid", pop_valid_o, pv);
    if (pv) begin
      d = '0;
      for (int k = 0; k < nb; k++) d |= 32'(q[k]) << (8 * k);
      chk(pop_data_o == d, "R11 pop_data", pop_data_o, d);
    end
    if (fl) q.delete();
    else begin
      pop_ok  = pp && (sz_q >= nb);
      push_ok = we && (16 - sz_q >= nb);
      m = (sz == 5'd31) ? 32'hFFFF_FFFF : ((32'd1 << (sz + 1)) - 32'd1);
      if (pop_ok) for (int k = 0; k < nb; k++) void'(q.pop_front());
      if (push_ok) for (int k = 0; k < nb; k++) q.push_back(8'((wd & m) >> (8 * k)));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(level_o == 0, "R1 reset level", level_o, 0);
    rst_ni = 1'b1;
    cyc(5'd7, 0, 0, 0, 0, 1, 1);

    // R2: 1-byte words fill to 16, 17th dropped (R4)
    for (int i = 0; i < 16; i++) cyc(5'd7, 0, 1, 32'hA500 + i, 0, 1, 1);
    cyc(5'd7, 0, 1, 32'h77, 0, 1, 1);
    cyc(5'd7, 0, 0, 0, 0, 1, 1);
    chk(level_o == 16, "R4 full write dropped", level_o, 16);
    chk(pop_data_o == 32'h00, "R4 head unchanged", pop_data_o, 32'h00);
    // R10: push and pop together at full: push dropped, level 15
    cyc(5'd7, 0, 1, 32'h99, 1, 0, 0);
    cyc(5'd7, 0, 0, 0, 0, 0, 0);
    chk(level_o == 15, "R10 net level", level_o, 15);
    for (int i = 0; i < 15; i++) cyc(5'd7, 0, 0, 0, 1, 0, 0);
    cyc(5'd7, 0, 0, 0, 1, 0, 0);
    chk(level_o == 0, "R5 empty pop ignored", level_o, 0);

    // R2/R3: 9-bit words with garbage above bit 8
    cyc(5'd8, 0, 1, 32'hFFFF_FF3C, 0, 0, 0);
    cyc(5'd8, 0, 0, 0, 0, 0, 0);
    chk(level_o == 2, "R2 two bytes", level_o, 2);
    chk(pop_data_o == 32'h13C, "R3 masked", pop_data_o, 32'h13C);
    cyc(5'd8, 0, 0, 0, 1, 0, 0);

    // 24-bit words: four fit, fifth dropped, tx_empty falls
    for (int i = 0; i < 5; i++) cyc(5'd23, 0, 1, 32'hDE00_0000 | (i * 32'h010203), 0, 1, 1);
    cyc(5'd23, 0, 0, 0, 0, 1, 1);
    chk(level_o == 16, "R2 four-byte words", level_o, 16);
    chk(tx_empty_o == 0 && irq_o == 0 && dma_req_o == 0, "R6 full flags", tx_empty_o, 0);

    // R9: flush held with write and pop attempts
    cyc(5'd23, 1, 1, 32'h1234, 1, 1, 1);
    cyc(5'd23, 1, 1, 32'h1234, 1, 1, 1);
    chk(level_o == 0 && tx_empty_o == 0, "R9 flush holds", level_o, 0);
    cyc(5'd23, 0, 1, 32'h00AB_CDEF, 0, 1, 1);
    cyc(5'd23, 0, 0, 0, 0, 1, 1);
    chk(level_o == 4 && pop_data_o == 32'h00AB_CDEF, "R9 resume", pop_data_o, 32'h00AB_CDEF);
    cyc(5'd23, 0, 0, 0, 1, 0, 0);

    // R11: random mix, wrap-around and size changes
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [4:0] sz;
      r = $urandom_range(0, 2);
      sz = (r == 0) ? 5'($urandom_range(0, 7)) : (r == 1) ? 5'($urandom_range(8, 15))
                                                         : 5'($urandom_range(16, 31));
      cyc(sz, ($urandom_range(0, 99) == 0), $urandom_range(0, 1), $urandom,
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    cyc(5'd7, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule